// File: doc/BRIEF.md
# Interrupt Pin Output Stage

This block sits between the embedded motion event detectors of an accelerometer and its two interrupt pins. It takes six event indications and a data-ready indication, holds or follows them according to the configuration, and exposes the held event state as source-register contents. Each pin is driven by the OR of the sources enabled in that pin's mask.

The pin stage can be set to either polarity and to either drive style. In push-pull style the pin is always driven. In open-drain style it is driven only while active. In latched mode, an event stays asserted until software reads its source register, or reads the combined all-sources register. Data-ready is never latched. While the sensor is powered down, no interrupt reaches a pin and no new event is recorded.

Event index assignment, used for event inputs, read strobes, flags and mask bits alike: 0 free-fall, 1 wake-up, 2 orientation change, 3 single tap, 4 double tap, 5 activity change.

Top module: `irq_pin_stage`

## Requirements
- R1: With `active_low_i`=0, an inactive pin reads 0 and an active pin reads 1. With `active_low_i`=1, both levels are inverted.
- R2: With `open_drain_i`=0, `pin_oe_o` is 1 for every pin. With `open_drain_i`=1, a pin's `pin_oe_o` is 1 exactly while that pin is active.
- R3: With `latch_i`=1, an event seen for one cycle sets its flag in `src_flags_o` one cycle later. The flag then stays set until a clearing read.
- R4: With `latch_i`=0, each flag equals its event input delayed by one cycle.
- R5: `drdy_status_o` equals `drdy_i` delayed by one cycle, whatever `latch_i` is. Data-ready reaches a pin through `drdy_mask_i` (bit p for pin p).
- R6: In latched mode, a pulse on `src_rd_i[k]` clears flag k on the next edge. A read strobe for another index leaves flag k set.
- R7: A pulse on `all_rd_i` clears every latched flag on the next edge.
- R8: An event present in the same cycle as a clearing read of its flag leaves the flag set.
- R9: While `sensor_on_i`=0, both pins are inactive in the same cycle. Events and data-ready arriving in that time set no flag, and flags already held keep their value.
- R10: Pin p is active when any flag k with `evt_mask_i[p*6+k]`=1 is set, or when `drdy_status_o` is set and `drdy_mask_i[p]`=1. Otherwise pin p is inactive.
- R11: After reset all flags and `drdy_status_o` are 0 and both pins are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sensor_on_i | input | 1 | 1 while the sensor is converting, 0 in power-down |
| active_low_i | input | 1 | Pin polarity select |
| open_drain_i | input | 1 | Drive style select: 1 open-drain, 0 push-pull |
| latch_i | input | 1 | Latched event mode |
| evt_i | input | 6 | Event pulses or levels, by event index |
| drdy_i | input | 1 | Data-ready indication |
| evt_mask_i | input | 12 | Event enables, pin p in bits p*6+5..p*6 |
| drdy_mask_i | input | 2 | Data-ready enable per pin |
| src_rd_i | input | 6 | Source-register read strobe per event |
| all_rd_i | input | 1 | Combined all-sources read strobe |
| pin_o | output | 2 | Pin level |
| pin_oe_o | output | 2 | Pin output enable |
| src_flags_o | output | 6 | Held event flags (source-register contents) |
| drdy_status_o | output | 1 | Data-ready status |

## Verification
The event set path and the read-clear path can land in the same cycle. This is provoked by driving an event bit together with the read strobe for that same flag on one falling edge, and separately together with the all-sources strobe. The result is judged one edge later: the colliding flag and the pin routed to it must still be set and active. Any other flags swept by the all-sources read must be clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int EVT_N = 6;
  localparam int PIN_N = 2;

  typedef enum logic [2:0] {
    EV_FREEFALL = 3'd0,
    EV_WAKE     = 3'd1,
    EV_ORIENT   = 3'd2,
    EV_TAP1     = 3'd3,
    EV_TAP2     = 3'd4,
    EV_ACTCHG   = 3'd5
  } evt_idx_e;

  typedef struct packed {
    logic active_low;
    logic open_drain;
  } drive_cfg_t;
endpackage

// File: rtl/irq_event_hold.sv
module irq_event_hold #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         latch_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (latch_i) q <= set_i[i] | (q & ~clr_i[i]);
      else              q <= set_i[i];
    end
    assign flags_o[i] = q;

    a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_i && q && !clr_i[i]) |=> q);
    a_r4_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_i) |=> (q == $past(set_i[i])));
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_i && clr_i[i] && !set_i[i]) |=> !q);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q);
  end
endmodule

// File: rtl/irq_pin_route.sv
module irq_pin_route #(
  parameter int N = 6,
  parameter int P = 2
) (
  input  logic [N-1:0]   flags_i,
  input  logic           drdy_i,
  input  logic [P*N-1:0] evt_mask_i,
  input  logic [P-1:0]   drdy_mask_i,
  input  logic           enable_i,
  output logic [P-1:0]   act_o
);
  for (genvar p = 0; p < P; p++) begin : g_pin
    logic hit;
    assign hit      = |(flags_i & evt_mask_i[p*N +: N]) | (drdy_i & drdy_mask_i[p]);
    assign act_o[p] = hit & enable_i;
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_pkg::*;
#(
  parameter int P = 2
) (
  input  logic [P-1:0] act_i,
  input  drive_cfg_t   cfg_i,
  output logic [P-1:0] pin_o,
  output logic [P-1:0] oe_o
);
  for (genvar p = 0; p < P; p++) begin : g_pin
    assign pin_o[p] = act_i[p] ^ cfg_i.active_low;
    assign oe_o[p]  = cfg_i.open_drain ? act_i[p] : 1'b1;
  end
endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage
  import irq_pkg::*;
#(
  parameter int N = EVT_N,
  parameter int P = PIN_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sensor_on_i,
  input  logic           active_low_i,
  input  logic           open_drain_i,
  input  logic           latch_i,
  input  logic [N-1:0]   evt_i,
  input  logic           drdy_i,
  input  logic [P*N-1:0] evt_mask_i,
  input  logic [P-1:0]   drdy_mask_i,
  input  logic [N-1:0]   src_rd_i,
  input  logic           all_rd_i,
  output logic [P-1:0]   pin_o,
  output logic [P-1:0]   pin_oe_o,
  output logic [N-1:0]   src_flags_o,
  output logic           drdy_status_o
);
  logic [N-1:0] set_gated;
  logic [N-1:0] clr_any;
  logic [P-1:0] act;
  logic         drdy_q;
  drive_cfg_t   dcfg;

  assign set_gated = evt_i & {N{sensor_on_i}};
  assign clr_any   = src_rd_i | {N{all_rd_i}};
  assign dcfg      = '{active_low: active_low_i, open_drain: open_drain_i};

  // data-ready bypasses the latch: plain one-cycle register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drdy_q <= 1'b0;
    else        drdy_q <= drdy_i & sensor_on_i;
  end
  assign drdy_status_o = drdy_q;

  irq_event_hold #(.N(N)) u_hold (
    .clk(clk), .rst_n(rst_n), .latch_i(latch_i),
    .set_i(set_gated), .clr_i(clr_any), .flags_o(src_flags_o)
  );

  irq_pin_route #(.N(N), .P(P)) u_route (
    .flags_i(src_flags_o), .drdy_i(drdy_q), .evt_mask_i(evt_mask_i),
    .drdy_mask_i(drdy_mask_i), .enable_i(sensor_on_i), .act_o(act)
  );

  irq_pin_drive #(.P(P)) u_drive (
    .act_i(act), .cfg_i(dcfg), .pin_o(pin_o), .oe_o(pin_oe_o)
  );

  a_r5_drdy_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drdy_status_o == $past(drdy_i && sensor_on_i)));
  a_r2_push_pull_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !open_drain_i |-> (&pin_oe_o));
  a_r9_off_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !sensor_on_i |-> (pin_o == {P{active_low_i}}));
  a_r9_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!sensor_on_i && open_drain_i) |-> (pin_oe_o == '0));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (src_flags_o == '0 && !drdy_status_o) |-> (pin_o == {P{active_low_i}}));
  a_r7_all_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_i && all_rd_i && !sensor_on_i) |=> (src_flags_o == '0));
endmodule

// File: tb/irq_pin_stage_bench.sv
module irq_pin_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sensor_on_i = 1'b1;
  logic        active_low_i = 1'b0;
  logic        open_drain_i = 1'b0;
  logic        latch_i = 1'b0;
  logic [5:0]  evt_i = '0;
  logic        drdy_i = 1'b0;
  logic [11:0] evt_mask_i = '0;
  logic [1:0]  drdy_mask_i = '0;
  logic [5:0]  src_rd_i = '0;
  logic        all_rd_i = 1'b0;
  logic [1:0]  pin_o;
  logic [1:0]  pin_oe_o;
  logic [5:0]  src_flags_o;
  logic        drdy_status_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_pin_stage u_irq_pin_stage (
    .clk(clk), .rst_n(rst_n), .sensor_on_i(sensor_on_i),
    .active_low_i(active_low_i), .open_drain_i(open_drain_i), .latch_i(latch_i),
    .evt_i(evt_i), .drdy_i(drdy_i), .evt_mask_i(evt_mask_i),
    .drdy_mask_i(drdy_mask_i), .src_rd_i(src_rd_i), .all_rd_i(all_rd_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .src_flags_o(src_flags_o),
    .drdy_status_o(drdy_status_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_pins(string req, logic [1:0] act);
    logic [1:0] lvl;
    logic [1:0] oe;
    lvl = active_low_i ? ~act : act;
    oe  = open_drain_i ? act : 2'b11;
    n_cmp++;
    if (pin_o !== lvl || pin_oe_o !== oe) begin
      n_bad++;
      $display("FAIL %s pins: got lvl=%b oe=%b expected lvl=%b oe=%b",
               req, pin_o, pin_oe_o, lvl, oe);
    end
  endtask

  task automatic chk_flags(string req, logic [5:0] exp);
    n_cmp++;
    if (src_flags_o !== exp) begin
      n_bad++;
      $display("FAIL %s flags: got %b expected %b", req, src_flags_o, exp);
    end
  endtask

  task automatic chk_drdy(string req, logic exp);
    n_cmp++;
    if (drdy_status_o !== exp) begin
      n_bad++;
      $display("FAIL %s drdy: got %b expected %b", req, drdy_status_o, exp);
    end
  endtask

  task automatic flush();
    logic keep;
    keep = latch_i;
    latch_i = 1'b1; all_rd_i = 1'b1; evt_i = '0; drdy_i = 1'b0;
    step();
    all_rd_i = 1'b0; latch_i = keep;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk_flags("R11", 6'b0);
    chk_pins("R11", 2'b00);
    chk_drdy("R11", 1'b0);
    rst_n = 1'b1;
    step();
    chk_pins("R11", 2'b00);

    // sweep: polarity x drive x latch x event index
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 6; k++) begin
        active_low_i = c[0]; open_drain_i = c[1]; latch_i = c[2];
        evt_mask_i   = {~(6'd1 << k), 6'd1 << k};
        drdy_mask_i  = 2'b00;
        flush();
        chk_flags("R7", 6'b0);
        chk_pins("R1", 2'b00);
        evt_i = 6'd1 << k;
        step();
        evt_i = '0;
        chk_flags(latch_i ? "R3" : "R4", 6'd1 << k);
        chk_pins("R10", 2'b01);
        step();
        if (latch_i) begin
          chk_flags("R3", 6'd1 << k);
          chk_pins("R3", 2'b01);
          src_rd_i = 6'd1 << ((k + 1) % 6);
          step();
          chk_flags("R6", 6'd1 << k);
          src_rd_i = 6'd1 << k;
          step();
          src_rd_i = '0;
          chk_flags("R6", 6'b0);
          chk_pins("R6", 2'b00);
        end else begin
          chk_flags("R4", 6'b0);
          chk_pins("R4", 2'b00);
        end
      end
    end

    // R5: data-ready unaffected by latch mode
    for (int c = 0; c < 4; c++) begin
      active_low_i = c[0]; open_drain_i = c[1]; latch_i = 1'b1;
      evt_mask_i = '0; drdy_mask_i = 2'b10;
      flush();
      drdy_i = 1'b1;
      step();
      chk_drdy("R5", 1'b1);
      chk_pins("R5", 2'b10);
      drdy_i = 1'b0;
      step();
      chk_drdy("R5", 1'b0);
      chk_pins("R5", 2'b00);
    end

    // R8: event collides with its own source read, then with all-read
    active_low_i = 1'b0; open_drain_i = 1'b1; latch_i = 1'b1;
    evt_mask_i = {6'b000000, 6'b111111}; drdy_mask_i = 2'b00;
    flush();
    evt_i = 6'b000100;
    step();
    src_rd_i = 6'b000100;
    step();
    evt_i = '0; src_rd_i = '0;
    chk_flags("R8", 6'b000100);
    chk_pins("R8", 2'b01);
    evt_i = 6'b001000; all_rd_i = 1'b1;
    step();
    evt_i = '0; all_rd_i = 1'b0;
    chk_flags("R8", 6'b001000);

    // R7: several flags cleared by one combined read
    evt_i = 6'b101011;
    step();
    evt_i = '0;
    chk_flags("R7", 6'b101011);
    all_rd_i = 1'b1;
    step();
    all_rd_i = 1'b0;
    chk_flags("R7", 6'b0);
    chk_pins("R7", 2'b00);

    // R9: power-down
    active_low_i = 1'b1; open_drain_i = 1'b0;
    evt_mask_i = {6'b111111, 6'b111111}; drdy_mask_i = 2'b11;
    evt_i = 6'b000001;
    step();
    evt_i = '0;
    chk_pins("R9", 2'b11);
    sensor_on_i = 1'b0;
    #1;
    chk_pins("R9", 2'b00);
    evt_i = 6'b111110; drdy_i = 1'b1;
    step();
    evt_i = '0; drdy_i = 1'b0;
    chk_flags("R9", 6'b000001);
    chk_drdy("R9", 1'b0);
    chk_pins("R9", 2'b00);
    sensor_on_i = 1'b1;
    #1;
    chk_pins("R9", 2'b11);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule